// File: doc/BRIEF.md
# DDR3 Read/Write Column Command Scheduler

This block sits between a request queue and the command bus of a DDR3 memory controller. Each request carries a direction (read or write), a bank, a column and the per-command burst-select bit. On every controller clock the block drives one column command: READ, WRITE or NOP. It holds a request through a valid/ready handshake until the spacing rules allow it, and then issues it in the earliest legal cycle.

The spacing rules are computed at run time from programmable additive, CAS and CAS-write latencies. Read latency is additive plus CAS latency, and write latency is additive plus CAS-write latency. A read followed by a write needs the longer turnaround RL + tCCD + 2 − WL. The block also decodes the burst length from the mode field and the burst-select bit. It raises a read-data-valid window exactly where the read data is due back.

The latency and mode inputs are taken live while nothing is in flight. They are frozen while any burst or spacing interval is still pending, so commands already issued keep the timing they were given.

Top module: `rts_turnaround_sched`

## Requirements
- R1: Read latency is RL = AL + CL. The first clock of the read data window of a READ issued in cycle t is cycle t + RL (RL of at least 1 assumed).
- R2: `rd_data_valid` is high for exactly 4 consecutive clocks (t+RL to t+RL+3) for each READ. Windows of closely spaced reads merge, and the output is low in every other cycle.
- R3: A READ after a READ, a WRITE after a WRITE and a READ after a WRITE are each at least TCCD clocks apart (TCCD parameter, default 4).
- R4: A WRITE after a READ is at least max(RL + TCCD + 2 − WL, TCCD) clocks later, where WL = AL + CWL.
- R5: The block is work-conserving. A pending request is issued in the first cycle the spacing rules allow, which is the same cycle it is presented when the block is idle.
- R6: A command leaves only in a cycle where `req_valid` and `req_ready` are both high, and that request is consumed in that cycle. `cmd_op` encodes 2'b00 NOP, 2'b01 READ and 2'b10 WRITE. `cmd_bank` and `cmd_col` repeat the request's bank and column.
- R7: The mode field selects the burst length on `cmd_bl8`. 2'b00 gives 8 beats. 2'b01 gives 8 beats when `req_a12` is 1 and a 4-beat chop when it is 0. 2'b10 gives a 4-beat chop. 2'b11 gives 8 beats. A chop does not shorten any spacing.
- R8: The latency and mode inputs take effect only while the block is idle. A change made while a burst or spacing interval is outstanding is ignored for all commands until the block is idle again.
- R9: During and after reset the bus shows NOP, `rd_data_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_al | input | 4 | Additive latency in clocks |
| cfg_cl | input | 5 | CAS latency in clocks |
| cfg_cwl | input | 5 | CAS-write latency in clocks |
| cfg_bl_mode | input | 2 | Burst-length mode field |
| req_valid | input | 1 | A request is pending |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_a12 | input | 1 | Per-command burst select (1 = 8 beats in mode 2'b01) |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | The pending request may issue this cycle |
| cmd_op | output | 2 | Column command: 00 NOP, 01 READ, 10 WRITE |
| cmd_bank | output | BANK_W | Bank of the issued command, 0 on NOP |
| cmd_col | output | COL_W | Column of the issued command, 0 on NOP |
| cmd_bl8 | output | 1 | Issued command is an 8-beat burst |
| rd_data_valid | output | 1 | Read data window |

## Verification
The assertions check the following on every cycle: the three TCCD spacings and the read-to-write turnaround, measured from the latencies in force at the read; that commands appear only under a completed handshake; the fixed burst modes; that latency stays frozen while busy; and that the data-valid flag never outlives the window of the last read. Only the bench's scenarios can show the rest. These are the exact issue cycle chosen, the exact first and last clock of each data window, the A12-driven burst choice, and that a latency change made mid-flight is held back and then takes effect once the block is idle. The bench sweeps AL, CL, CWL and the mode field over a small grid and computes every gap and window arithmetically.

// File: rtl/rts_pkg.sv
`timescale 1ns/1ps
package rts_pkg;
  localparam int AL_W   = 4;
  localparam int CL_W   = 5;
  localparam int CWL_W  = 5;
  localparam int MODE_W = 2;
  // latency sum width: the widest term plus one carry bit
  localparam int LAT_W  = CL_W + 1;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } cmd_op_e;

  typedef struct packed {
    logic [AL_W-1:0]   al;
    logic [CL_W-1:0]   cl;
    logic [CWL_W-1:0]  cwl;
    logic [MODE_W-1:0] mode;
  } cfg_t;
endpackage

// File: rtl/rts_cfg_hold.sv
`timescale 1ns/1ps
module rts_cfg_hold
  import rts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  cfg_t             cfg_in,
  output logic [MODE_W-1:0] mode_eff,
  output logic [LAT_W-1:0] rl,
  output logic [LAT_W-1:0] wl
);
  cfg_t cfg_q;
  cfg_t cfg_eff;

  // live inputs while idle, frozen copy while anything is in flight
  always_comb begin
    cfg_eff  = idle ? cfg_in : cfg_q;
    mode_eff = cfg_eff.mode;
    rl       = LAT_W'(cfg_eff.al) + LAT_W'(cfg_eff.cl);
    wl       = LAT_W'(cfg_eff.al) + LAT_W'(cfg_eff.cwl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (idle) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/rts_burst_decode.sv
`timescale 1ns/1ps
module rts_burst_decode
  import rts_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              a12,
  output logic              bl8
);
  always_comb begin
    unique case (mode)
      2'b00:   bl8 = 1'b1;  // fixed 8 beats
      2'b01:   bl8 = a12;   // chosen per command
      2'b10:   bl8 = 1'b0;  // fixed 4-beat chop
      default: bl8 = 1'b1;
    endcase
  end
endmodule

// File: rtl/rts_spacing.sv
`timescale 1ns/1ps
module rts_spacing #(
  parameter int TCCD  = 4,
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic             wr_fire,
  input  logic [LAT_W-1:0] rl,
  input  logic [LAT_W-1:0] wl,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             idle
);
  localparam int CNT_W = LAT_W + 2;
  localparam logic [CNT_W-1:0] TCCD_M1 = CNT_W'(TCCD - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] rd_wait_q, rd_wait_n;
  logic [CNT_W-1:0] wr_wait_q, wr_wait_n;
  logic [CNT_W-1:0] drain_q, drain_n;
  logic [CNT_W-1:0] rw_sum, wl_ccd, rw_gap;

  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  function automatic logic [CNT_W-1:0] vmax(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // read-to-write turnaround: RL + TCCD + 2 - WL, never below TCCD
  always_comb begin
    rw_sum = CNT_W'(rl) + CNT_W'(TCCD + 2);
    wl_ccd = CNT_W'(wl) + CNT_W'(TCCD);
    rw_gap = (rw_sum > wl_ccd) ? (rw_sum - CNT_W'(wl)) : CNT_W'(TCCD);
  end

  always_comb begin
    rd_wait_n = dec_sat(rd_wait_q);
    wr_wait_n = dec_sat(wr_wait_q);
    drain_n   = dec_sat(drain_q);
    if (rd_fire) begin
      rd_wait_n = vmax(rd_wait_n, TCCD_M1);
      wr_wait_n = vmax(wr_wait_n, rw_gap - ONE);
      drain_n   = vmax(drain_n, CNT_W'(rl) + CNT_W'(3));
    end
    if (wr_fire) begin
      rd_wait_n = vmax(rd_wait_n, TCCD_M1);
      wr_wait_n = vmax(wr_wait_n, TCCD_M1);
      drain_n   = vmax(drain_n, CNT_W'(wl) + CNT_W'(3));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_wait_q <= '0;
      wr_wait_q <= '0;
      drain_q   <= '0;
    end else begin
      rd_wait_q <= rd_wait_n;
      wr_wait_q <= wr_wait_n;
      drain_q   <= drain_n;
    end
  end

  assign rd_ok = (rd_wait_q == '0);
  assign wr_ok = (wr_wait_q == '0);
  assign idle  = rd_ok && wr_ok && (drain_q == '0);
endmodule

// File: rtl/rts_rd_window.sv
`timescale 1ns/1ps
module rts_rd_window #(
  parameter int LAT_W = 6,
  parameter int DEPTH = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             rd_fire,
  input  logic [LAT_W-1:0] rl,
  output logic             rd_data_valid
);
  logic [DEPTH-1:0] hist_q, hist_n;

  // bit k set: a READ left k+1 cycles ago; cleared once idle so stale
  // history can never meet a newly loaded latency
  always_comb begin
    if (idle) hist_n = {{(DEPTH-1){1'b0}}, rd_fire};
    else      hist_n = {hist_q[DEPTH-2:0], rd_fire};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  always_comb begin
    rd_data_valid = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (hist_q[k] && ((k + 1) >= int'(rl)) && ((k + 1) <= int'(rl) + 3))
        rd_data_valid = 1'b1;
    end
    if (idle) rd_data_valid = 1'b0;
  end
endmodule

// File: rtl/rts_turnaround_sched.sv
`timescale 1ns/1ps
module rts_turnaround_sched
  import rts_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int TCCD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AL_W-1:0]   cfg_al,
  input  logic [CL_W-1:0]   cfg_cl,
  input  logic [CWL_W-1:0]  cfg_cwl,
  input  logic [MODE_W-1:0] cfg_bl_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_a12,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_bl8,
  output logic              rd_data_valid
);
  localparam int RL_MAX = (2**AL_W - 1) + (2**CL_W - 1);
  localparam int DEPTH  = RL_MAX + 4;

  cfg_t              cfg_in;
  logic [MODE_W-1:0] mode_eff;
  logic [LAT_W-1:0]  rl, wl;
  logic              idle, rd_ok, wr_ok;
  logic              fire, rd_fire, wr_fire, bl8;

  assign cfg_in = '{al: cfg_al, cl: cfg_cl, cwl: cfg_cwl, mode: cfg_bl_mode};

  rts_cfg_hold u_cfg (
    .clk(clk), .rst_n(rst_n), .idle(idle), .cfg_in(cfg_in),
    .mode_eff(mode_eff), .rl(rl), .wl(wl)
  );

  rts_spacing #(.TCCD(TCCD), .LAT_W(LAT_W)) u_space (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .rl(rl), .wl(wl), .rd_ok(rd_ok), .wr_ok(wr_ok), .idle(idle)
  );

  rts_burst_decode u_bl (.mode(mode_eff), .a12(req_a12), .bl8(bl8));

  rts_rd_window #(.LAT_W(LAT_W), .DEPTH(DEPTH)) u_win (
    .clk(clk), .rst_n(rst_n), .idle(idle), .rd_fire(rd_fire),
    .rl(rl), .rd_data_valid(rd_data_valid)
  );

  always_comb begin
    req_ready = req_write ? wr_ok : rd_ok;
    fire      = req_valid && req_ready;
    rd_fire   = fire && !req_write;
    wr_fire   = fire && req_write;
    cmd_op    = OP_NOP;
    if (rd_fire) cmd_op = OP_READ;
    if (wr_fire) cmd_op = OP_WRITE;
    cmd_bank  = fire ? req_bank : '0;
    cmd_col   = fire ? req_col  : '0;
    cmd_bl8   = fire && bl8;
  end
endmodule

// File: rtl/rts_turnaround_chk.sv
`timescale 1ns/1ps
module rts_turnaround_chk
  import rts_pkg::*;
#(
  parameter int TCCD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_op,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cmd_bl8,
  input logic             rd_data_valid,
  input logic             idle,
  input logic [LAT_W-1:0] rl,
  input logic [LAT_W-1:0] wl,
  input logic [1:0]       mode
);
  logic [7:0] since_rd, since_wr, gap_cap;
  logic [LAT_W-1:0] rl_cap;
  logic rd_seen, wr_seen;
  int g;

  always_comb begin
    g = int'(rl) + TCCD + 2 - int'(wl);
    if (g < TCCD) g = TCCD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rd <= '0; since_wr <= '0; gap_cap <= '0; rl_cap <= '0;
      rd_seen <= 1'b0; wr_seen <= 1'b0;
    end else begin
      if (cmd_op == 2'b01) begin
        since_rd <= 8'd1; rd_seen <= 1'b1; gap_cap <= 8'(g); rl_cap <= rl;
      end else if (since_rd != 8'hff) since_rd <= since_rd + 8'd1;
      if (cmd_op == 2'b10) begin
        since_wr <= 8'd1; wr_seen <= 1'b1;
      end else if (since_wr != 8'hff) since_wr <= since_wr + 8'd1;
    end
  end

  p_rr_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b01 && rd_seen) |-> (since_rd >= 8'(TCCD)));
  p_ww_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b10 && wr_seen) |-> (since_wr >= 8'(TCCD)));
  p_wr_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b01 && wr_seen) |-> (since_wr >= 8'(TCCD)));
  p_rw_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'b10 && rd_seen) |-> (since_rd >= gap_cap));
  p_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (cmd_op != 2'b00));
  p_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> (cmd_op == 2'b00));
  p_bl_fixed8_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 2'b00 && mode == 2'b00) |-> cmd_bl8);
  p_bl_chop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 2'b00 && mode == 2'b10) |-> !cmd_bl8);
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (idle || $stable(rl)));
  p_rdv_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> (rd_seen && ({1'b0, since_rd} <= 9'(rl_cap) + 9'd3)));
endmodule

bind rts_turnaround_sched rts_turnaround_chk #(.TCCD(TCCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .req_valid(req_valid),
  .req_ready(req_ready), .cmd_bl8(cmd_bl8), .rd_data_valid(rd_data_valid),
  .idle(idle), .rl(rl), .wl(wl), .mode(mode_eff)
);

// File: tb/rts_turnaround_sched_test.sv
`timescale 1ns/1ps
module rts_turnaround_sched_test;
  localparam int BANK_W = 3;
  localparam int COL_W  = 10;
  localparam int TCCD   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_al = '0;
  logic [4:0] cfg_cl = 5'd5;
  logic [4:0] cfg_cwl = 5'd5;
  logic [1:0] cfg_bl_mode = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_a12 = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic req_ready;
  logic [1:0] cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0]  cmd_col;
  logic cmd_bl8, rd_data_valid;

  rts_turnaround_sched #(.BANK_W(BANK_W), .COL_W(COL_W), .TCCD(TCCD)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
    .cfg_cwl(cfg_cwl), .cfg_bl_mode(cfg_bl_mode), .req_valid(req_valid),
    .req_write(req_write), .req_a12(req_a12), .req_bank(req_bank),
    .req_col(req_col), .req_ready(req_ready), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_bl8(cmd_bl8),
    .rd_data_valid(rd_data_valid)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int exp_rl = 5;
  int cur_mode = 0;
  bit mon_on = 1'b0;
  int rd_t [16];
  int rd_l [16];
  int rd_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R1 and R2: expected window from every recorded READ and its latency
  always @(negedge clk) begin
    if (mon_on) begin
      int e;
      #2;
      e = 0;
      for (int i = 0; i < 16; i++)
        if ((cyc - rd_t[i]) >= rd_l[i] && (cyc - rd_t[i]) <= rd_l[i] + 3) e = 1;
      chk(rd_data_valid == e[0], "R1/R2", "rd_data_valid", int'(rd_data_valid), e);
    end
  end

  // called just after a falling edge; returns just after a falling edge
  task automatic send(input bit w, input bit a12, output int t);
    bit done;
    int eb;
    done = 1'b0;
    req_valid = 1'b1; req_write = w; req_a12 = a12;
    req_bank = BANK_W'(cyc); req_col = COL_W'(cyc * 7);
    while (!done) begin
      #1;
      if (req_ready) begin
        t = cyc;
        chk(cmd_op == (w ? 2'b10 : 2'b01), "R6", "cmd_op on issue", int'(cmd_op), w ? 2 : 1);
        chk(cmd_bank == req_bank && cmd_col == req_col, "R6", "bank/col pass-through",
            int'(cmd_col), int'(req_col));
        eb = (cur_mode == 1) ? int'(a12) : (cur_mode != 2) ? 1 : 0;
        chk(int'(cmd_bl8) == eb, "R7", "cmd_bl8", int'(cmd_bl8), eb);
        if (!w) begin
          rd_t[rd_n % 16] = t; rd_l[rd_n % 16] = exp_rl; rd_n++;
        end
        done = 1'b1;
      end else begin
        chk(cmd_op == 2'b00, "R6", "NOP while stalled", int'(cmd_op), 0);
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, t4, t5, s, rl, wl;
    for (int i = 0; i < 16; i++) begin rd_t[i] = -1000; rd_l[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    chk(cmd_op == 2'b00, "R9", "cmd_op in reset", int'(cmd_op), 0);
    chk(rd_data_valid == 1'b0, "R9", "rd_data_valid in reset", int'(rd_data_valid), 0);
    chk(req_ready == 1'b1, "R9", "req_ready in reset", int'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    #1;
    chk(cmd_op == 2'b00 && req_ready, "R9", "idle after reset", int'(cmd_op), 0);
    @(negedge clk);

    // sweep of latencies and burst modes
    for (int al = 0; al <= 2; al++)
      for (int cl = 5; cl <= 8; cl++)
        for (int cwl = 5; cwl <= 7; cwl++) begin
          repeat (24) @(negedge clk);
          cfg_al = 4'(al); cfg_cl = 5'(cl); cfg_cwl = 5'(cwl);
          cur_mode = (al + cl + cwl) % 4;
          cfg_bl_mode = 2'(cur_mode);
          rl = al + cl; wl = al + cwl; exp_rl = rl;
          s = cyc;
          send(1'b0, 1'b1, t0);
          chk(t0 == s, "R5", "idle READ issues at once", t0 - s, 0);
          send(1'b1, 1'b0, t1);
          chk(t1 - t0 == imax(rl + TCCD + 2 - wl, TCCD), "R4", "READ->WRITE gap",
              t1 - t0, imax(rl + TCCD + 2 - wl, TCCD));
          send(1'b1, 1'b1, t2);
          chk(t2 - t1 == TCCD, "R3", "WRITE->WRITE gap", t2 - t1, TCCD);
          send(1'b0, 1'b0, t3);
          chk(t3 - t2 == TCCD, "R3", "WRITE->READ gap", t3 - t2, TCCD);
          send(1'b0, 1'b1, t4);
          chk(t4 - t3 == TCCD, "R3", "READ->READ gap", t4 - t3, TCCD);
          repeat (2) @(negedge clk);
          send(1'b0, 1'b0, t5);
          chk(t5 - t4 == TCCD, "R5", "late READ issues at earliest cycle", t5 - t4, TCCD);
        end

    // R8: change latency and mode while busy; old values stay in force
    repeat (30) @(negedge clk);
    cfg_al = 4'd0; cfg_cl = 5'd5; cfg_cwl = 5'd5; cfg_bl_mode = 2'b00;
    cur_mode = 0; exp_rl = 5;
    send(1'b0, 1'b0, t0);
    cfg_cl = 5'd8; cfg_bl_mode = 2'b10;
    send(1'b1, 1'b0, t1);
    chk(t1 - t0 == 6, "R8", "gap keeps old latency", t1 - t0, 6);
    send(1'b0, 1'b0, t2);
    chk(t2 - t1 == TCCD, "R8", "WRITE->READ under frozen config", t2 - t1, TCCD);
    repeat (30) @(negedge clk);
    cur_mode = 2; exp_rl = 8;
    send(1'b0, 1'b1, t3);
    send(1'b1, 1'b1, t4);
    chk(t4 - t3 == 9, "R8", "new latency after idle", t4 - t3, 9);
    repeat (30) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule